// File: doc/BRIEF.md
# Guard-Round-Sticky Mantissa Rounding Stage

This stage takes an unpacked floating-point mantissa carrying two extra low-order bits (guard above round) and a separate sticky bit. It removes the two extra bits, decides whether the remaining value must be bumped by one unit in the last place under the selected rounding direction, and performs that increment with a carry through every bit. The rounded mantissa, a rounded-up indication and three status flags leave the stage together from one output register.

The stage sits between an arithmetic datapath and a packing step. The consumer fixes the exponent after a carry-out, for example when an all-ones fraction rounds up to the next power of two. For that reason the output is one bit wider than the kept fraction. Input and output each use a valid/ready handshake. There is one register stage, and a full output that is not taken stalls the input.

Top module: `grs_round_unit`

## Requirements
- R1: With no increment, the output mantissa equals the input mantissa shifted right by two, zero-extended to FRAC_W+1 bits.
- R2: When guard (input bit 1), round (input bit 0) and sticky are all zero, there is no increment, and inexact, fraction-inexact, fraction-rounded and rounded-up are all low.
- R3: When any of guard, round or sticky is set, both inexact and fraction-inexact are high.
- R4: Mode 2'b00 (nearest) increments only when guard is set and at least one of round, sticky or the shifted LSB (input bit 2) is set, so exact halfway cases go to the even neighbour.
- R5: Mode 2'b01 (toward zero) never increments.
- R6: Mode 2'b10 (toward plus infinity) increments an inexact value only when sign is 0.
- R7: Mode 2'b11 (toward minus infinity) increments an inexact value only when sign is 1.
- R8: Whenever an increment happens, both fraction-rounded and rounded-up are high. Otherwise both are low.
- R9: The increment carries through the whole kept fraction. All-ones plus one gives bit FRAC_W set and all lower bits zero.
- R10: An input is taken on a clock edge where in_valid and in_ready are both high. Its result is presented with out_valid on the next cycle. in_ready is high exactly when out_valid is low or out_ready is high.
- R11: While out_valid is high and out_ready is low, the output mantissa and all flags hold their values.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Stage can take an input this cycle |
| mant_in | input | FRAC_W+2 | Mantissa; bit 1 guard, bit 0 round |
| sticky_in | input | 1 | OR of all bits below round |
| sign_in | input | 1 | 1 = negative value |
| mode_in | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| mant_out | output | FRAC_W+1 | Rounded mantissa, bit FRAC_W is carry-out |
| rnd_up_out | output | 1 | Increment applied |
| inexact_out | output | 1 | Any discarded bit was nonzero |
| frac_inexact_out | output | 1 | Fraction inexact status |
| frac_rnd_out | output | 1 | Fraction was rounded up |

## Verification
The bench builds the stage with FRAC_W = 8, so the input mantissa is 10 bits wide. This makes it practical to sweep every mantissa value against every mode, sign and sticky setting. Every halfway case is reached, and so is the all-ones carry into bit 8, which at the default width would be a rare corner. The sweep runs with random back-pressure on out_ready, so stalls and hold behaviour are exercised throughout, not only in a separate directed test.

// File: rtl/grs_pkg.sv
package grs_pkg;
    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_ZERO = 2'b01,
        RND_POS  = 2'b10,
        RND_NEG  = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/grs_decide.sv
module grs_decide
    import grs_pkg::*;
(
    input  logic      guard_i,
    input  logic      round_i,
    input  logic      sticky_i,
    input  logic      lsb_i,
    input  logic      sign_i,
    input  logic [1:0] mode_i,
    output logic      inexact_o,
    output logic      inc_o
);
    always_comb begin
        inexact_o = guard_i | round_i | sticky_i;
        inc_o     = 1'b0;
        if (inexact_o) begin
            unique case (rnd_mode_e'(mode_i))
                RND_NEAR: inc_o = guard_i & (round_i | sticky_i | lsb_i);
                RND_ZERO: inc_o = 1'b0;
                RND_POS:  inc_o = ~sign_i;
                RND_NEG:  inc_o = sign_i;
                default:  inc_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/grs_incr.sv
module grs_incr #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         inc_i,
    output logic [W:0]   sum_o
);
    logic [W:0] carry;
    assign carry[0] = inc_i;
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign sum_o[b]   = val_i[b] ^ carry[b];
        assign carry[b+1] = val_i[b] & carry[b];
    end
    assign sum_o[W] = carry[W];
endmodule

// File: rtl/grs_round_unit.sv
module grs_round_unit
    import grs_pkg::*;
#(
    parameter int FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FRAC_W+1:0] mant_in,
    input  logic              sticky_in,
    input  logic              sign_in,
    input  logic [1:0]        mode_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FRAC_W:0]   mant_out,
    output logic              rnd_up_out,
    output logic              inexact_out,
    output logic              frac_inexact_out,
    output logic              frac_rnd_out
);
    localparam int IN_W  = FRAC_W + 2;
    localparam int OUT_W = FRAC_W + 1;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] mant;
        logic             up;
        logic             inexact;
        logic             frac_inexact;
        logic             frac_rnd;
    } stage_t;

    stage_t st_d, st_q;

    logic [FRAC_W-1:0] kept_w;
    logic [OUT_W-1:0]  sum_w;
    logic              inc_w;
    logic              inexact_w;
    logic              take_w;

    assign kept_w = mant_in[IN_W-1:2];

    grs_decide u_decide (
        .guard_i  (mant_in[1]),
        .round_i  (mant_in[0]),
        .sticky_i (sticky_in),
        .lsb_i    (mant_in[2]),
        .sign_i   (sign_in),
        .mode_i   (mode_in),
        .inexact_o(inexact_w),
        .inc_o    (inc_w)
    );

    grs_incr #(.W(FRAC_W)) u_incr (
        .val_i(kept_w),
        .inc_i(inc_w),
        .sum_o(sum_w)
    );

    assign in_ready = ~st_q.valid | out_ready;
    assign take_w   = in_valid & in_ready;

    always_comb begin
        st_d = st_q;
        if (take_w) begin
            st_d.valid        = 1'b1;
            st_d.mant         = sum_w;
            st_d.up           = inc_w;
            st_d.inexact      = inexact_w;
            st_d.frac_inexact = inexact_w;
            st_d.frac_rnd     = inc_w;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid        = st_q.valid;
    assign mant_out         = st_q.mant;
    assign rnd_up_out       = st_q.up;
    assign inexact_out      = st_q.inexact;
    assign frac_inexact_out = st_q.frac_inexact;
    assign frac_rnd_out     = st_q.frac_rnd;
endmodule

// File: rtl/grs_round_unit_chk.sv
module grs_round_unit_chk #(
    parameter int FRAC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [FRAC_W+1:0] mant_in,
    input logic              sticky_in,
    input logic              sign_in,
    input logic [1:0]        mode_in,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FRAC_W:0]   mant_out,
    input logic              rnd_up_out,
    input logic              inexact_out,
    input logic              frac_inexact_out,
    input logic              frac_rnd_out
);
    // R11
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(mant_out) && $stable(rnd_up_out)
            && $stable(inexact_out) && $stable(frac_rnd_out));

    // R2
    exact_no_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !inexact_out |-> !rnd_up_out && !frac_rnd_out && !frac_inexact_out);

    // R8
    up_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rnd_up_out == frac_rnd_out) && (!rnd_up_out || inexact_out));

    // R5
    zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && mode_in == 2'b01 |=> !rnd_up_out);

    // R10
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R3
    inexact_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (mant_in[1:0] != 2'b00 || sticky_in) |=> inexact_out && frac_inexact_out);
endmodule

bind grs_round_unit grs_round_unit_chk #(.FRAC_W(FRAC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mant_in(mant_in), .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
    .out_valid(out_valid), .out_ready(out_ready), .mant_out(mant_out),
    .rnd_up_out(rnd_up_out), .inexact_out(inexact_out),
    .frac_inexact_out(frac_inexact_out), .frac_rnd_out(frac_rnd_out)
);

// File: tb/grs_round_unit_tb_top.sv
module grs_round_unit_tb_top;
    localparam int FW = 8;
    localparam int IW = FW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] mant_in = '0;
    logic          sticky_in = 1'b0;
    logic          sign_in = 1'b0;
    logic [1:0]    mode_in = 2'b00;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [FW:0]   mant_out;
    logic          rnd_up_out, inexact_out, frac_inexact_out, frac_rnd_out;

    always #4 clk = ~clk;

    grs_round_unit #(.FRAC_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mant_in(mant_in), .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
        .out_valid(out_valid), .out_ready(out_ready), .mant_out(mant_out),
        .rnd_up_out(rnd_up_out), .inexact_out(inexact_out),
        .frac_inexact_out(frac_inexact_out), .frac_rnd_out(frac_rnd_out)
    );

    typedef struct packed {
        logic [3:0]  tag;
        logic [FW:0] mant;
        logic        up;
        logic        inx;
        logic        frnd;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   stall_en = 1'b0;

    task automatic check(input int tag, input bit ok, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", tag, act, expv);
        end
    endtask

    // reference model, written from R1..R9
    function automatic exp_t model(input logic [IW-1:0] m, input bit s, input bit sg, input logic [1:0] md);
        exp_t e;
        logic [FW-1:0] q;
        bit g, r, inx, inc;
        q   = m[IW-1:2];
        g   = m[1];
        r   = m[0];
        inx = g | r | s;
        inc = 1'b0;
        if (inx) begin
            case (md)
                2'b00: inc = g && (r || s || q[0]);
                2'b01: inc = 1'b0;
                2'b10: inc = !sg;
                default: inc = sg;
            endcase
        end
        e.mant = {1'b0, q} + (FW+1)'(inc);
        e.up   = inc;
        e.inx  = inx;
        e.frnd = inc;
        if (!inx)              e.tag = (q == 0) ? 4'd2 : 4'd1;   // R2 / R1
        else if (inc && &q)    e.tag = 4'd9;                     // R9
        else if (md == 2'b01)  e.tag = 4'd5;                     // R5
        else if (!inc)         e.tag = 4'd3;                     // R3
        else if (md == 2'b00)  e.tag = 4'd4;                     // R4
        else if (md == 2'b10)  e.tag = 4'd6;                     // R6
        else                   e.tag = 4'd7;                     // R7
        return e;
    endfunction

    task automatic drive(input logic [IW-1:0] m, input bit s, input bit sg, input logic [1:0] md, input int tag);
        exp_t e;
        bit done;
        e = model(m, s, sg, md);
        if (tag != 0) e.tag = 4'(tag);
        @(negedge clk);
        in_valid  = 1'b1;
        mant_in   = m;
        sticky_in = s;
        sign_in   = sg;
        mode_in   = md;
        done = 1'b0;
        while (!done) begin
            #1;
            if (in_ready) begin
                exp_q.push_back(e);
                done = 1'b1;
                @(posedge clk);
            end else begin
                @(negedge clk);
            end
        end
        #1 in_valid = 1'b0;
    endtask

    // back-pressure generator
    always @(negedge clk) out_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;

    // monitor / scoreboard
    bit          held = 1'b0;
    logic [FW:0] held_mant;
    logic [3:0]  held_flags;
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && out_valid) begin
                if (held) begin // R11: stalled output must not move
                    check(11, mant_out == held_mant &&
                          {rnd_up_out, inexact_out, frac_inexact_out, frac_rnd_out} == held_flags,
                          32'(mant_out), 32'(held_mant));
                end
                if (out_ready) begin
                    held = 1'b0;
                    if (exp_q.size() == 0) begin
                        check(10, 1'b0, 32'(mant_out), 32'hDEAD);
                    end else begin
                        e = exp_q.pop_front();
                        check(int'(e.tag), mant_out == e.mant, 32'(mant_out), 32'(e.mant));
                        check(int'(e.tag), {rnd_up_out, frac_rnd_out} == {e.up, e.frnd},
                              32'({rnd_up_out, frac_rnd_out}), 32'({e.up, e.frnd}));
                        check(int'(e.tag), {inexact_out, frac_inexact_out} == {e.inx, e.inx},
                              32'({inexact_out, frac_inexact_out}), 32'({e.inx, e.inx}));
                    end
                end else begin
                    held       = 1'b1;
                    held_mant  = mant_out;
                    held_flags = {rnd_up_out, inexact_out, frac_inexact_out, frac_rnd_out};
                end
            end else begin
                held = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, 1'b0, 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R12: reset state
        check(12, out_valid == 1'b0, 32'(out_valid), 32'd0);
        check(12, in_ready == 1'b1, 32'(in_ready), 32'd1);

        // R10: one-cycle latency with a ready consumer
        @(negedge clk);
        in_valid = 1'b1; mant_in = 10'b0000000101; sticky_in = 0; sign_in = 0; mode_in = 2'b00;
        exp_q.push_back(model(10'b0000000101, 1'b0, 1'b0, 2'b00));
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check(10, out_valid == 1'b1, 32'(out_valid), 32'd1);
        repeat (2) @(negedge clk);

        // directed corners
        drive(10'b1111111111, 1'b0, 1'b0, 2'b00, 9);   // R9 carry-out
        drive(10'b0000000110, 1'b0, 1'b0, 2'b00, 4);   // R4 tie, odd -> up
        drive(10'b0000001010, 1'b0, 1'b0, 2'b00, 4);   // R4 tie, even -> stays
        drive(10'b0000001011, 1'b0, 1'b0, 2'b00, 8);   // R8 up flags
        drive(10'b1010101000, 1'b0, 1'b1, 2'b11, 1);   // R1 exact shift
        drive(10'b0000000000, 1'b1, 1'b1, 2'b01, 5);   // R5 sticky only
        drive(10'b0000000001, 1'b0, 1'b0, 2'b10, 6);   // R6 positive up
        drive(10'b0000000001, 1'b0, 1'b1, 2'b10, 6);   // R6 negative stays
        drive(10'b0000000010, 1'b0, 1'b1, 2'b11, 7);   // R7 negative up
        drive(10'b0000000010, 1'b0, 1'b0, 2'b11, 7);   // R7 positive stays
        drive(10'b0000000100, 1'b0, 1'b0, 2'b10, 2);   // R2 exact
        drive(10'b0000000001, 1'b0, 1'b0, 2'b00, 3);   // R3 inexact, no up

        // full sweep under back-pressure
        stall_en = 1'b1;
        for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
                for (int s = 0; s < 2; s++)
                    for (int m = 0; m < (1 << IW); m++)
                        drive(IW'(m), s[0], sg[0], md[1:0], 0);
        stall_en = 1'b0;
        repeat (6) @(negedge clk);
        check(10, exp_q.size() == 0, 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule